// File: doc/BRIEF.md
# Mixed-Sign Byte Dot-Product Accumulator

This block is a lane array for vector integer arithmetic. Every 32-bit lane takes four bytes from an unsigned operand vector and four bytes from a signed operand vector, multiplies each matching pair, adds the four products together and adds a signed 32-bit accumulator lane. The 32-bit result wraps on overflow and never saturates. The number of lanes is a parameter. An active-lane count input says how many of the low lanes carry a live result, and every lane above that count comes out as zero.

Operations arrive with a 32-bit operation word, a feature-enable bit and the three operand vectors, under a valid/ready handshake. A small decoder checks the fixed opcode bits and the element-size field of the operation word. An operation that fails that check, or that arrives while the feature-enable bit is low, still passes through the pipeline. It leaves as a one-cycle illegal-operation pulse and produces no result. The datapath has two register stages: the products and the adder tree come first, then the accumulation. A legal result is presented two cycles after its operation is accepted, and it is held while the consumer stalls.

Top module: `mixdot_accum`

## Requirements
- R1: Each byte of `src_u` is taken as an unsigned value from 0 to 255. Each byte of `src_s` is taken as a two's-complement signed value from -128 to 127. Their product is the exact signed product (for example 0xFF times 0x80 gives -32640).
- R2: Result lane i (bits 32i+31 down to 32i) uses byte 4i+k of `src_u` together with byte 4i+k of `src_s` for k = 0 to 3. Byte n sits at bits 8n+7 down to 8n.
- R3: Result lane i equals `acc_in` lane i plus the sum of its four byte products, taken modulo 2^32 with no saturation.
- R4: An operation whose size field, `op_word[23:22]`, is not 2 gives a one-cycle `illegal_op` pulse and no `out_valid`.
- R5: An operation is legal only if `op_word[31:24]` is 8'h44, `op_word[21]` is 0 and `op_word[15:10]` is 6'b011110. Any other value is handled as in R4. Bits 20:16 and 9:0 have no effect.
- R6: An operation accepted while `feat_en` is low is handled as in R4.
- R7: Result lanes i with i >= `act_lanes` are zero. A count of LANES or more makes every lane active.
- R8: With `out_ready` high, `out_valid` or `illegal_op` rises in the second cycle after the accepting clock edge of the operation, and stays low in the cycle before that.
- R9: While `out_valid` is high and `out_ready` is low, `res_o` and `out_valid` hold. Once both pipeline stages are occupied, `in_ready` goes low. After the stall, results leave in the order their operations were accepted.
- R10: After reset, `out_valid` and `illegal_op` are low and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| op_word | input | 32 | Operation word checked by the decoder |
| feat_en | input | 1 | Feature enable; an operation is legal only when this is high |
| act_lanes | input | $clog2(LANES+1) | Number of active low lanes |
| src_u | input | LANES*32 | Unsigned byte operand vector |
| src_s | input | LANES*32 | Signed byte operand vector |
| acc_in | input | LANES*32 | Signed 32-bit accumulator lanes |
| out_valid | output | 1 | Legal result present |
| out_ready | input | 1 | Consumer takes the result |
| illegal_op | output | 1 | One-cycle pulse for a rejected operation |
| res_o | output | LANES*32 | Result lanes |

## Verification
Two things can happen in the same cycle: a held result stalls the output stage, and a new operation is taken into the first stage. The bench provokes this by lowering `out_ready` and offering three operations back to back. It judges that the first result stays unchanged and `in_ready` falls only once the third operation has nowhere to go. It then releases the stall and checks that the three results come out in order, each with its own expected value. Corner bytes 0x00, 0x7F, 0x80 and 0xFF, with accumulators at the positive and negative limits, test wrap-around. Random operands and lane counts are checked against a reference computed in the bench.

// File: rtl/mixdot_pkg.sv
// Package: shared constants and the pipeline token type for the mixed-sign
// dot-product accumulator. Assumes 8-bit bytes and 32-bit result lanes.
package mixdot_pkg;
    localparam int BYTE_W = 8;
    localparam int LANE_W = 32;
    localparam int BYTES_PER_LANE = LANE_W / BYTE_W;
    // An unsigned-by-signed byte product lies in [-32640, 32385]: 17 bits signed.
    localparam int PROD_W = 17;
    // Two adder levels over four products add two bits.
    localparam int TREE_W = PROD_W + 2;

    localparam logic [7:0] OPC_TOP   = 8'h44;
    localparam logic [5:0] OPC_MID   = 6'b011110;
    localparam logic [1:0] SIZE_WORD = 2'd2;

    typedef enum logic [1:0] {
        TOK_NONE    = 2'd0,
        TOK_LEGAL   = 2'd1,
        TOK_ILLEGAL = 2'd2
    } tok_e;
endpackage

// File: rtl/mixdot_decode.sv
// Module: operation decoder. Checks the fixed opcode bits, the element-size
// field and the feature-enable bit. Register-number fields are ignored
// because the operands arrive directly as data. Purely combinational.
module mixdot_decode
    import mixdot_pkg::*;
(
    input  logic [31:0] op_word,
    input  logic        feat_en,
    output logic        legal
);
    logic top_ok;
    logic mid_ok;
    logic size_ok;
    logic unused_fields;

    // Fixed-bit pattern match.
    always_comb begin
        top_ok  = (op_word[31:24] == OPC_TOP) && (op_word[21] == 1'b0);
        mid_ok  = (op_word[15:10] == OPC_MID);
        size_ok = (op_word[23:22] == SIZE_WORD);
    end

    // Final verdict: pattern, size and feature all required.
    assign legal = top_ok && mid_ok && size_ok && feat_en;

    assign unused_fields = ^{op_word[20:16], op_word[9:0]};
endmodule

// File: rtl/mixdot_lane_tree.sv
// Module: one lane's product stage. Forms four unsigned-by-signed byte
// products and reduces them with a two-level adder tree. Assumes four bytes
// per lane; byte k of one operand pairs with byte k of the other.
module mixdot_lane_tree
    import mixdot_pkg::*;
#(
    parameter int BW = BYTE_W,
    parameter int PW = PROD_W,
    parameter int NB = BYTES_PER_LANE
) (
    input  logic [NB*BW-1:0]        u_bytes,
    input  logic [NB*BW-1:0]        s_bytes,
    output logic signed [PW+1:0]    tree_sum
);
    logic signed [PW-1:0] prod [NB];
    logic signed [PW:0]   pair [NB/2];

    for (genvar k = 0; k < NB; k++) begin : g_prod
        logic signed [PW-1:0] u_ext;
        logic signed [PW-1:0] s_ext;
        // Zero-extend the unsigned byte, sign-extend the signed byte, multiply.
        always_comb begin
            u_ext   = {{(PW-BW){1'b0}}, u_bytes[k*BW +: BW]};
            s_ext   = {{(PW-BW){s_bytes[k*BW+BW-1]}}, s_bytes[k*BW +: BW]};
            prod[k] = u_ext * s_ext;
        end
    end

    for (genvar j = 0; j < NB/2; j++) begin : g_pair
        // First adder level: neighbouring products.
        assign pair[j] = {prod[2*j][PW-1], prod[2*j]} + {prod[2*j+1][PW-1], prod[2*j+1]};
    end

    // Second adder level.
    assign tree_sum = {pair[0][PW], pair[0]} + {pair[1][PW], pair[1]};
endmodule

// File: rtl/mixdot_lane_acc.sv
// Module: one lane's accumulate stage. Sign-extends the tree sum, adds the
// 32-bit accumulator with wrap-around, and forces inactive lanes to zero.
module mixdot_lane_acc
    import mixdot_pkg::*;
#(
    parameter int LW = LANE_W,
    parameter int TW = TREE_W
) (
    input  logic signed [TW-1:0] tree_sum,
    input  logic [LW-1:0]        acc,
    input  logic                 active,
    output logic [LW-1:0]        result
);
    logic [LW-1:0] sum_ext;

    // Widen the tree sum and accumulate modulo 2^LW.
    always_comb begin
        sum_ext = {{(LW-TW){tree_sum[TW-1]}}, tree_sum};
        result  = active ? (acc + sum_ext) : '0;
    end
endmodule

// File: rtl/mixdot_accum.sv
// Module: top of the mixed-sign byte dot-product accumulator. Two register
// stages: stage 1 holds the per-lane tree sums, accumulators and lane mask;
// stage 2 holds the accumulated result. Rejected operations travel as an
// illegal token and leave as a one-cycle pulse without waiting for the
// consumer. Assumes operands are stable while in_valid is high.
module mixdot_accum
    import mixdot_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        in_valid,
    output logic                        in_ready,
    input  logic [31:0]                 op_word,
    input  logic                        feat_en,
    input  logic [$clog2(LANES+1)-1:0]  act_lanes,
    input  logic [LANES*LANE_W-1:0]     src_u,
    input  logic [LANES*LANE_W-1:0]     src_s,
    input  logic [LANES*LANE_W-1:0]     acc_in,
    output logic                        out_valid,
    input  logic                        out_ready,
    output logic                        illegal_op,
    output logic [LANES*LANE_W-1:0]     res_o
);
    localparam int ACT_W = $clog2(LANES+1);
    localparam int VEC_W = LANES * LANE_W;

    logic                     dec_legal;
    logic                     accept;
    logic                     s2_adv;
    logic [LANES-1:0]         act_mask;
    logic signed [TREE_W-1:0] tree_sum [LANES];
    logic [VEC_W-1:0]         s2_next;

    tok_e                     s1_tok;
    logic signed [TREE_W-1:0] s1_sum [LANES];
    logic [VEC_W-1:0]         s1_acc;
    logic [LANES-1:0]         s1_mask;

    tok_e                     s2_tok;
    logic [VEC_W-1:0]         s2_res;
    logic [LANES-1:0]         s2_mask;

    mixdot_decode u_dec (
        .op_word (op_word),
        .feat_en (feat_en),
        .legal   (dec_legal)
    );

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        // Lane is live when its index is below the active count.
        assign act_mask[g] = (ACT_W'(g) < act_lanes);

        mixdot_lane_tree u_tree (
            .u_bytes  (src_u[g*LANE_W +: LANE_W]),
            .s_bytes  (src_s[g*LANE_W +: LANE_W]),
            .tree_sum (tree_sum[g])
        );

        mixdot_lane_acc u_acc (
            .tree_sum (s1_sum[g]),
            .acc      (s1_acc[g*LANE_W +: LANE_W]),
            .active   (s1_mask[g]),
            .result   (s2_next[g*LANE_W +: LANE_W])
        );
    end

    // Handshake: stage 2 moves unless it holds a legal result that is stalled.
    always_comb begin
        s2_adv   = !((s2_tok == TOK_LEGAL) && !out_ready);
        in_ready = (s1_tok == TOK_NONE) || s2_adv;
        accept   = in_valid && in_ready;
    end

    // Stage 1 register: capture tree sums, accumulators, mask and verdict.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_tok  <= TOK_NONE;
            s1_acc  <= '0;
            s1_mask <= '0;
            for (int i = 0; i < LANES; i++) s1_sum[i] <= '0;
        end else if (in_ready) begin
            s1_tok <= accept ? (dec_legal ? TOK_LEGAL : TOK_ILLEGAL) : TOK_NONE;
            if (accept) begin
                s1_acc  <= acc_in;
                s1_mask <= act_mask;
                for (int i = 0; i < LANES; i++) s1_sum[i] <= tree_sum[i];
            end
        end
    end

    // Stage 2 register: accumulated result and the token that owns it.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_tok  <= TOK_NONE;
            s2_res  <= '0;
            s2_mask <= '0;
        end else if (s2_adv) begin
            s2_tok  <= s1_tok;
            s2_res  <= s2_next;
            s2_mask <= s1_mask;
        end
    end

    assign out_valid  = (s2_tok == TOK_LEGAL);
    assign illegal_op = (s2_tok == TOK_ILLEGAL);
    assign res_o      = s2_res;

    AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(res_o))); // R9

    AST_ACCEPT_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && dec_legal) |=> (s1_tok == TOK_LEGAL)); // R8

    AST_ILLEGAL_SRC: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> ($past(s1_tok) == TOK_ILLEGAL)); // R4

    AST_NO_DUAL: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_op |-> !out_valid); // R6

    for (genvar g = 0; g < LANES; g++) begin : g_tail_chk
        AST_ZERO_TAIL: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !s2_mask[g]) |-> (res_o[g*LANE_W +: LANE_W] == '0)); // R7
    end
endmodule

// File: tb/sim_mixdot_accum.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random operands, checked against
// a reference computed from the requirements. Inputs change on the falling
// edge; outputs are sampled on the falling edge.
module sim_mixdot_accum;
    localparam int LANES = 4;
    localparam int VW    = LANES * 32;
    localparam int AW    = $clog2(LANES+1);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          in_valid;
    logic          in_ready;
    logic [31:0]   op_word;
    logic          feat_en;
    logic [AW-1:0] act_lanes;
    logic [VW-1:0] src_u, src_s, acc_in;
    logic          out_valid;
    logic          out_ready;
    logic          illegal_op;
    logic [VW-1:0] res_o;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    mixdot_accum #(.LANES(LANES)) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
        .op_word(op_word), .feat_en(feat_en), .act_lanes(act_lanes),
        .src_u(src_u), .src_s(src_s), .acc_in(acc_in),
        .out_valid(out_valid), .out_ready(out_ready),
        .illegal_op(illegal_op), .res_o(res_o)
    );

    function automatic logic [31:0] mk_op(input logic [1:0] size);
        return {8'h44, size, 1'b0, 5'd7, 6'b011110, 5'd3, 5'd9};
    endfunction

    function automatic logic [VW-1:0] ref_vec(input logic [VW-1:0] u, s, a, input int act);
        logic [VW-1:0] r;
        int sum, ub, sb;
        logic signed [7:0] sb8;
        r = '0;
        for (int i = 0; i < LANES; i++) begin
            if (i < act) begin
                sum = int'(a[i*32 +: 32]);
                for (int k = 0; k < 4; k++) begin
                    ub  = int'({24'b0, u[(4*i+k)*8 +: 8]});
                    sb8 = s[(4*i+k)*8 +: 8];
                    sb  = int'(sb8);
                    sum = sum + ub * sb;
                end
                r[i*32 +: 32] = sum;
            end
        end
        return r;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [VW-1:0] actual, input logic [VW-1:0] expected);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, actual, expected);
        end
    endtask

    task automatic drive(input logic [31:0] op, input logic fe, input logic [AW-1:0] act,
                         input logic [VW-1:0] u, s, a);
        op_word = op; feat_en = fe; act_lanes = act;
        src_u = u; src_s = s; acc_in = a; in_valid = 1'b1;
    endtask

    // One operation with the consumer always ready; checks latency and result.
    task automatic run_one(input string tag, input logic [31:0] op, input logic fe,
                           input logic [AW-1:0] act, input logic [VW-1:0] u, s, a,
                           input bit legal);
        logic [VW-1:0] exp_v;
        exp_v = ref_vec(u, s, a, int'(act));
        @(negedge clk);
        out_ready = 1'b1;
        drive(op, fe, act, u, s, a);
        @(negedge clk);
        in_valid = 1'b0;
        chk(!out_valid && !illegal_op, "R8 early output", {126'b0, out_valid, illegal_op}, '0);
        @(negedge clk);
        chk(out_valid == legal, {tag, " out_valid"}, VW'(out_valid), VW'(legal));
        chk(illegal_op == !legal, {tag, " illegal_op"}, VW'(illegal_op), VW'(!legal));
        if (legal) chk(res_o == exp_v, {tag, " result"}, res_o, exp_v);
        @(negedge clk);
        chk(!illegal_op && !out_valid, "R8 single-cycle output", {126'b0, out_valid, illegal_op}, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [VW-1:0] ua, sa, aa, ub, sb, ab, uc, sc, ac, ea, eb, ec;
        logic [31:0] seedv;
        seedv = $urandom(32'd20240611);
        rst_n = 1'b0; in_valid = 1'b0; out_ready = 1'b1;
        drive(mk_op(2'd2), 1'b1, AW'(LANES), '0, '0, '0);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!out_valid && !illegal_op && in_ready, "R10 reset state",
            {125'b0, out_valid, illegal_op, in_ready}, VW'(1));

        // R1: extreme unsigned times extreme signed.
        run_one("R1 ff*80", mk_op(2'd2), 1'b1, AW'(LANES), {16{8'hFF}}, {16{8'h80}}, '0, 1'b1);
        run_one("R1 80*7f", mk_op(2'd2), 1'b1, AW'(LANES), {16{8'h80}}, {16{8'h7F}}, '0, 1'b1);
        run_one("R1 00*80", mk_op(2'd2), 1'b1, AW'(LANES), {16{8'h00}}, {16{8'h80}}, {4{32'd5}}, 1'b1);
        run_one("R1 ff*ff", mk_op(2'd2), 1'b1, AW'(LANES), {16{8'hFF}}, {16{8'hFF}}, {4{32'hFFFF_FFFF}}, 1'b1);
        // R2: distinct bytes per position expose any pairing swap.
        run_one("R2 pairing", mk_op(2'd2), 1'b1, AW'(LANES),
                128'h0102_0304_1122_3344_FF00_7F80_0A0B_0C0D,
                128'h0000_0080_7F00_0000_01FF_0280_F0E0_D0C0, '0, 1'b1);
        // R3: wrap in both directions.
        run_one("R3 wrap up", mk_op(2'd2), 1'b1, AW'(LANES), {16{8'hFF}}, {16{8'h7F}},
                {4{32'h7FFF_FFFF}}, 1'b1);
        run_one("R3 wrap down", mk_op(2'd2), 1'b1, AW'(LANES), {16{8'hFF}}, {16{8'h80}},
                {4{32'h8000_0000}}, 1'b1);
        // R4: every other size value is rejected.
        run_one("R4 size0", mk_op(2'd0), 1'b1, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b0);
        run_one("R4 size1", mk_op(2'd1), 1'b1, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b0);
        run_one("R4 size3", mk_op(2'd3), 1'b1, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b0);
        // R5: broken fixed bits rejected; register fields ignored.
        run_one("R5 top bits", mk_op(2'd2) ^ 32'h0100_0000, 1'b1, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b0);
        run_one("R5 bit21", mk_op(2'd2) | 32'h0020_0000, 1'b1, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b0);
        run_one("R5 mid bits", mk_op(2'd2) ^ 32'h0000_0400, 1'b1, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b0);
        run_one("R5 reg fields", mk_op(2'd2) ^ 32'h001F_03FF, 1'b1, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b1);
        // R6: feature disabled.
        run_one("R6 feat off", mk_op(2'd2), 1'b0, AW'(LANES), {16{8'h11}}, {16{8'h22}}, '0, 1'b0);
        // R7: active-lane counts including zero and beyond LANES.
        for (int n = 0; n < 8; n++)
            run_one("R7 act lanes", mk_op(2'd2), 1'b1, AW'(n), {16{8'h33}}, {16{8'hC5}}, {4{32'h1234}}, 1'b1);

        // R9: stall with three operations in flight, then drain in order.
        ua = {4{32'h0102_0304}}; sa = {4{32'h7F80_01FF}}; aa = {4{32'd100}};
        ub = {4{32'hFFFF_FFFF}}; sb = {4{32'h8080_8080}}; ab = {4{32'd7}};
        uc = {4{32'h00FF_00FF}}; sc = {4{32'h7F7F_7F7F}}; ac = {4{32'hFFFF_0000}};
        ea = ref_vec(ua, sa, aa, LANES);
        eb = ref_vec(ub, sb, ab, LANES);
        ec = ref_vec(uc, sc, ac, LANES);
        @(negedge clk);
        out_ready = 1'b0;
        drive(mk_op(2'd2), 1'b1, AW'(LANES), ua, sa, aa);
        @(negedge clk);
        drive(mk_op(2'd2), 1'b1, AW'(LANES), ub, sb, ab);
        @(negedge clk);
        drive(mk_op(2'd2), 1'b1, AW'(LANES), uc, sc, ac);
        chk(out_valid && res_o == ea, "R9 first result", res_o, ea);
        chk(!in_ready, "R9 in_ready low when full", VW'(in_ready), '0);
        @(negedge clk);
        chk(out_valid && res_o == ea, "R9 result held", res_o, ea);
        chk(!in_ready, "R9 still blocked", VW'(in_ready), '0);
        out_ready = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk(out_valid && res_o == eb, "R9 second in order", res_o, eb);
        @(negedge clk);
        chk(out_valid && res_o == ec, "R9 third in order", res_o, ec);
        @(negedge clk);
        chk(!out_valid, "R9 drained", VW'(out_valid), '0);

        // Random operands and lane counts (R1, R2, R3, R7).
        for (int t = 0; t < 40; t++) begin
            logic [VW-1:0] ru, rs, ra;
            ru = {$urandom, $urandom, $urandom, $urandom};
            rs = {$urandom, $urandom, $urandom, $urandom};
            ra = {$urandom, $urandom, $urandom, $urandom};
            run_one("R3 random", mk_op(2'd2), 1'b1, AW'($urandom_range(0, LANES)), ru, rs, ra, 1'b1);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule